// File: doc/BRIEF.md
# Serial Byte Receiver with Look-Ahead Queue

This block turns an asynchronous serial line into bytes. Each frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit. There is no parity bit. Bit timing comes from a single-cycle enable input, `tick16`, which pulses sixteen times per bit period. The block does not generate that enable itself.

The line first passes through a two-stage synchronizer. A falling edge starts a candidate frame, and the line is checked again eight ticks later, near the middle of the start bit. After that confirmation each bit is sampled every sixteen ticks. If the stop sample is high, the byte goes into a sixteen-entry queue. If the stop sample is low, the frame is thrown away.

The queue shows its oldest byte on `rx_byte` before any read takes place. The consumer raises `rd_ack` once it has used that byte, which acknowledges it. The queue then advances at that clock edge. Three flags report the fill level: data present, half full and full. A synchronous `flush` input empties the queue.

Top module: `serial_rx_fifo`

## Requirements
- R1: While `rst_n` is low and right after it rises, `has_data`, `fifo_half` and `fifo_full` are all 0.
- R2: A frame consists of a low start bit, 8 data bits with bit 0 first, and a high stop bit, each lasting 16 `tick16` pulses. After such a frame, the byte is in the queue once the stop bit has ended.
- R3: A low pulse on `rx_serial` that returns high before the 8th tick after its falling edge starts no frame. A proper frame that follows it is received correctly.
- R4: A frame whose stop-bit sample is low is discarded. The queue occupancy and the head byte do not change.
- R5: `rx_byte` shows the oldest queued byte while `has_data` is 1, and it stays stable until it is acknowledged. Holding `rd_ack` high for one clock removes that byte at that edge. Bytes come out in the order they arrived.
- R6: `has_data` is 1 when the occupancy is at least 1. `fifo_half` is 1 when the occupancy is at least 8. `fifo_full` is 1 when the occupancy is exactly 16.
- R7: A byte that completes while the queue is full is dropped. The 16 bytes already stored are kept, unchanged and in order.
- R8: `flush` high for one clock empties the queue. A byte that completes in that same cycle is discarded. Later frames are received normally.
- R9: `rd_ack` has no effect while the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle enable pulse at 16 times the bit rate |
| rx_serial | input | 1 | Asynchronous serial line, idle high |
| rd_ack | input | 1 | Acknowledge of the head byte; advances the queue |
| flush | input | 1 | Synchronous queue clear |
| rx_byte | output | 8 | Oldest queued byte (look-ahead) |
| has_data | output | 1 | Queue holds at least one byte |
| fifo_full | output | 1 | Queue holds 16 bytes |
| fifo_half | output | 1 | Queue holds 8 or more bytes |

## Verification
The receiver is driven with frames carrying random byte values from a fixed seed. Any error in bit order or sample position shows up as a byte mismatch against the bench's reference queue.

The directed cases each isolate one mechanism:
- A short low glitch separates start validation from plain edge detection.
- A frame with a low stop bit separates framing checks from plain byte assembly.
- Filling the queue to exactly 7, 8, 15 and 16 entries pins down the flag thresholds.
- A 17th frame shows whether overflow drops the new byte or damages stored ones.

Acknowledges on an empty queue and a flush followed by a new frame round off the queue-management cases.

// File: rtl/srx_pkg.sv
package srx_pkg;

  // Receive engine phases.
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  // Half-full threshold test: occupancy at least half of the depth.
  function automatic logic at_half(input int unsigned occ, input int unsigned depth);
    return occ >= (depth / 2);
  endfunction

  // Full test.
  function automatic logic at_full(input int unsigned occ, input int unsigned depth);
    return occ == depth;
  endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int    STAGES    = 2,
  parameter logic  RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= RESET_VAL;
          else        chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= RESET_VAL;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          line_s,
  output logic [DW-1:0] byte_out,
  output logic          byte_done,
  output logic          frame_bad
);

  localparam int CW = $clog2(OSR);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] MID_T  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] FULL_T = CW'(OSR - 1);
  localparam logic [BW-1:0] LAST_B = BW'(DW - 1);

  rx_state_e     st;
  logic [CW-1:0] tcnt;
  logic [BW-1:0] bidx;
  logic [DW-1:0] shreg;
  logic          line_d;

  logic fall_edge;
  logic mid_hit;
  logic bit_hit;

  assign fall_edge = line_d && !line_s;
  assign mid_hit   = tick && (tcnt == MID_T);
  assign bit_hit   = tick && (tcnt == FULL_T);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= RX_IDLE;
      tcnt      <= '0;
      bidx      <= '0;
      shreg     <= '0;
      line_d    <= 1'b1;
      byte_done <= 1'b0;
      frame_bad <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      frame_bad <= 1'b0;
      line_d    <= line_s;
      case (st)
        RX_IDLE: begin
          if (fall_edge) begin
            st   <= RX_START;
            tcnt <= '0;
          end
        end
        RX_START: begin
          if (mid_hit) begin
            tcnt <= '0;
            bidx <= '0;
            st   <= line_s ? RX_IDLE : RX_DATA;
          end else if (tick) begin
            tcnt <= tcnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (bit_hit) begin
            shreg <= {line_s, shreg[DW-1:1]};
            tcnt  <= '0;
            if (bidx == LAST_B) st <= RX_STOP;
            else                bidx <= bidx + 1'b1;
          end else if (tick) begin
            tcnt <= tcnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (bit_hit) begin
            st        <= RX_IDLE;
            tcnt      <= '0;
            byte_done <= line_s;
            frame_bad <= !line_s;
          end else if (tick) begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  assign byte_out = shreg;

endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
  import srx_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     push,
  input  logic [DW-1:0]            wdata,
  input  logic                     pop,
  output logic [DW-1:0]            head,
  output logic [$clog2(DEPTH):0]   occ,
  output logic                     not_empty,
  output logic                     half,
  output logic                     full,
  output logic                     dropped
);

  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr;
  logic [AW-1:0] rptr;
  logic [AW:0]   count;

  logic wr_en;
  logic rd_en;

  assign full      = at_full(int'(count), DEPTH);
  assign half      = at_half(int'(count), DEPTH);
  assign not_empty = (count != '0);
  assign wr_en     = push && !full && !flush;
  assign rd_en     = pop && not_empty && !flush;
  assign dropped   = push && full && !flush;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_en) wptr <= wptr + 1'b1;
      if (rd_en) rptr <= rptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head = mem[rptr];
  assign occ  = count;

endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo #(
  parameter int DW       = 8,
  parameter int OSR      = 16,
  parameter int DEPTH    = 16,
  parameter int SYNC_STG = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic          rx_serial,
  input  logic          rd_ack,
  input  logic          flush,
  output logic [DW-1:0] rx_byte,
  output logic          has_data,
  output logic          fifo_full,
  output logic          fifo_half
);

  localparam int AW = $clog2(DEPTH);

  // Internal events, named for the checker.
  logic          line_s;
  logic [DW-1:0] asm_byte;
  logic          byte_done;
  logic          frame_bad;
  logic          byte_dropped;
  logic [AW:0]   occ;

  srx_sync #(.STAGES(SYNC_STG), .RESET_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rx_serial),
    .dout (line_s)
  );

  srx_frame #(.DW(DW), .OSR(OSR)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick16),
    .line_s   (line_s),
    .byte_out (asm_byte),
    .byte_done(byte_done),
    .frame_bad(frame_bad)
  );

  srx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .push     (byte_done),
    .wdata    (asm_byte),
    .pop      (rd_ack),
    .head     (rx_byte),
    .occ      (occ),
    .not_empty(has_data),
    .half     (fifo_half),
    .full     (fifo_full),
    .dropped  (byte_dropped)
  );

endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   flush,
  input logic                   rd_ack,
  input logic [DW-1:0]          rx_byte,
  input logic                   has_data,
  input logic                   fifo_full,
  input logic                   fifo_half,
  input logic                   byte_done,
  input logic                   frame_bad,
  input logic                   byte_dropped,
  input logic [$clog2(DEPTH):0] occ
);

  // R6: full implies the lower thresholds as well
  a_r6_full_implies_half: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> (fifo_half && has_data));

  // R2: a completed byte with room and no read grows the queue by one
  a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !fifo_full && !rd_ack && !flush) |=> (occ == $past(occ) + 1'b1));

  // R4: a bad stop leaves occupancy unchanged
  a_r4_bad_frame_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_bad && !rd_ack && !flush) |=> (occ == $past(occ)));

  // R5: head holds until acknowledged
  a_r5_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (has_data && !rd_ack && !flush) |=> (has_data && $stable(rx_byte)));

  // R7: full queue stays full and the byte is reported dropped
  a_r7_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && !rd_ack && !flush) |=> fifo_full);

  a_r7_drop_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    byte_dropped |-> (fifo_full && byte_done));

  // R8: flush empties the queue
  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!has_data && occ == '0));

  // R9: acknowledge on empty queue does nothing
  a_r9_empty_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!has_data && !byte_done) |=> !has_data);

endmodule

bind serial_rx_fifo srx_checker #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush       (flush),
  .rd_ack      (rd_ack),
  .rx_byte     (rx_byte),
  .has_data    (has_data),
  .fifo_full   (fifo_full),
  .fifo_half   (fifo_half),
  .byte_done   (byte_done),
  .frame_bad   (frame_bad),
  .byte_dropped(byte_dropped),
  .occ         (occ)
);

// File: tb/serial_rx_fifo_bench.sv
module serial_rx_fifo_bench;

  localparam int TDIV  = 4;
  localparam int QD    = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rx_serial = 1'b1;
  logic       rd_ack = 1'b0;
  logic       flush = 1'b0;
  logic [7:0] rx_byte;
  logic       has_data;
  logic       fifo_full;
  logic       fifo_half;

  int nvec = 0;
  int nerr = 0;
  bit done = 1'b0;
  int tdiv = 0;
  logic [7:0] refq[$];

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      tdiv   <= 0;
      tick16 <= 1'b0;
    end else begin
      tdiv   <= (tdiv == TDIV - 1) ? 0 : tdiv + 1;
      tick16 <= (tdiv == TDIV - 1);
    end
  end

  serial_rx_fifo u_serial_rx_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick16   (tick16),
    .rx_serial(rx_serial),
    .rd_ack   (rd_ack),
    .flush    (flush),
    .rx_byte  (rx_byte),
    .has_data (has_data),
    .fifo_full(fifo_full),
    .fifo_half(fifo_half)
  );

  function automatic logic exp_half(input int n);
    return n > 7;
  endfunction

  function automatic logic exp_full(input int n);
    return n >= QD;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag);
    int n;
    n = refq.size();
    chk({tag, " has_data"}, 32'(has_data), 32'(n != 0));
    chk({tag, " half"},     32'(fifo_half), 32'(exp_half(n)));
    chk({tag, " full"},     32'(fifo_full), 32'(exp_full(n)));
    if (n != 0) chk({tag, " head"}, 32'(rx_byte), 32'(refq[0]));
  endtask

  task automatic tick_wait(input int n);
    int k;
    k = 0;
    while (k < n) begin
      @(negedge clk);
      if (tick16) k++;
    end
  endtask

  task automatic send_frame(input logic [7:0] b, input bit stop_ok);
    rx_serial = 1'b0;
    tick_wait(16);
    for (int i = 0; i < 8; i++) begin
      rx_serial = b[i];
      tick_wait(16);
    end
    rx_serial = stop_ok;
    tick_wait(16);
    rx_serial = 1'b1;
    tick_wait(4);
  endtask

  task automatic pop_one(input string tag);
    chk({tag, " head before ack"}, 32'(rx_byte), 32'(refq[0]));
    rd_ack = 1'b1;
    @(negedge clk);
    rd_ack = 1'b0;
    void'(refq.pop_front());
    chk_state(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    void'($urandom(32'd4021));
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 has_data in reset", 32'(has_data), 32'd0);
    chk("R1 full in reset", 32'(fifo_full), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 half after reset", 32'(fifo_half), 32'd0);
    chk("R1 has_data after reset", 32'(has_data), 32'd0);
    tick_wait(20);

    // R2/R6: random bytes plus directed patterns
    for (int i = 0; i < 5; i++) begin
      b = (i == 3) ? 8'h00 : (i == 4) ? 8'hFF : 8'($urandom);
      send_frame(b, 1'b1);
      refq.push_back(b);
      chk_state("R2 frame");
    end

    // R5: look-ahead head and ordered acknowledge
    tick_wait(5);
    chk("R5 head stable while idle", 32'(rx_byte), 32'(refq[0]));
    while (refq.size() != 0) pop_one("R5 pop order");

    // R9: acknowledge on empty queue
    rd_ack = 1'b1;
    repeat (3) @(negedge clk);
    rd_ack = 1'b0;
    chk_state("R9 ack on empty");
    send_frame(8'hA5, 1'b1);
    refq.push_back(8'hA5);
    chk_state("R9 frame after empty ack");

    // R3: short glitch, then a real frame
    rx_serial = 1'b0;
    tick_wait(3);
    rx_serial = 1'b1;
    tick_wait(20);
    chk_state("R3 glitch ignored");
    send_frame(8'h3C, 1'b1);
    refq.push_back(8'h3C);
    chk_state("R3 frame after glitch");

    // R4: low stop bit discards the frame
    send_frame(8'h77, 1'b0);
    tick_wait(16);
    chk_state("R4 bad stop discarded");

    // R6: thresholds while filling
    while (refq.size() < QD) begin
      b = 8'($urandom);
      send_frame(b, 1'b1);
      refq.push_back(b);
      if (refq.size() == 7 || refq.size() == 8 || refq.size() == 15 || refq.size() == 16)
        chk_state("R6 thresholds");
    end

    // R7: overflow drops the new byte
    send_frame(8'hE1, 1'b1);
    chk_state("R7 overflow keeps contents");
    while (refq.size() != 0) pop_one("R7 drain order");

    // R8: flush
    for (int i = 0; i < 4; i++) begin
      b = 8'($urandom);
      send_frame(b, 1'b1);
      refq.push_back(b);
    end
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    refq.delete();
    chk_state("R8 flush empties");
    send_frame(8'h5A, 1'b1);
    refq.push_back(8'h5A);
    chk_state("R8 frame after flush");
    pop_one("R8 pop after flush");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule